// File: doc/BRIEF.md
# Reciprocal Square-Root Estimate Unit

This unit returns an 8-bit-accurate estimate of 1/sqrt(x) for a single-precision operand. It also has an unsigned fixed-point mode that treats the operand as a 32-bit fraction and returns a 9-bit estimate. It is a multi-cycle engine with a start/busy/done handshake. A caller raises `start` for one cycle while `busy` is low and then waits for the one-cycle `done` pulse. `result` and the three flags stay valid from that pulse until the next operation completes.

Operands that need no arithmetic (NaNs, zeros, negatives, infinities, and small values in the unsigned mode) finish in one cycle. For every other operand the unit first normalizes a subnormal one step per cycle. It then forms a 9-bit scaled input whose layout depends on whether the exponent is odd or even. Last, it searches upwards for the root one candidate per cycle, until the product of the adjusted input and the squared candidate reaches 2^28.

Top module: `rsqe_top`

## Requirements
- R1: After reset, `busy`, `done`, `result` and all three flags are 0.
- R2: A start is accepted only while `busy` is low. A start raised while `busy` is high has no effect on the running operation or its result. `busy` stays high from the cycle after an arithmetic start until `done` pulses. `done` is high for exactly one cycle per accepted operation.
- R3: The estimate is derived from a scaled input s in 128..511. If s < 256, let a = 2s+1; otherwise a = 2*((s with bit 0 cleared)+1). Starting from b = 512, b is incremented while a*(b+1)^2 < 2^28. The estimate is (b+1)/2, which lies in 256..511.
- R4: For a positive finite float operand with biased exponent e, the scaled input is 1 followed by fraction bits 22:16 when e is odd, and 1 followed by fraction bits 22:15 when e is even. The result has sign 0 and exponent (380-e)/2. The estimate's low 8 bits go in bits 22:15, bits 14:0 are 0, and no flag is raised.
- R5: When flush-to-zero is off, a subnormal operand is normalized before scaling. Its fraction is shifted left with e decremented per shift (starting from e = 0) until bit 22 is 1, then shifted once more to drop that bit. No flag is raised.
- R6: When flush-to-zero is on, a subnormal operand counts as a zero of the same sign and also raises the input-denormal flag.
- R7: A float zero returns infinity of the same sign (0x7F800000 or 0xFF800000) and raises divide-by-zero.
- R8: A negative nonzero, non-NaN float (including -inf) returns the default NaN 0x7FC00000 and raises invalid. +inf returns 0x00000000 with no flag.
- R9: A NaN is signaling when fraction bit 22 is 0. A signaling NaN raises invalid and is returned with bit 22 set. A quiet NaN is returned unchanged with no flag. With default-NaN mode on, any NaN returns 0x7FC00000 (a signaling one still raises invalid).
- R10: In unsigned mode (`mode_fixed`=1), an operand whose bits 31:30 are both 0 returns 0xFFFFFFFF. Otherwise bits 31:23 are the scaled input, and the 9-bit estimate is returned in bits 31:23 with bits 22:0 zero. No flag is ever raised in this mode.
- R11: Results that need no search pulse `done` in the cycle after the start. A search that takes N increments pulses `done` N+2 cycles after the accepting edge. A subnormal float with k leading zero fraction bits adds k+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted while busy is low) |
| operand | input | 32 | Float or unsigned fixed-point operand |
| mode_fixed | input | 1 | 1 = unsigned fixed-point mode, 0 = single-precision |
| ftz_en | input | 1 | Treat subnormal float inputs as zero |
| dnan_en | input | 1 | Return the default NaN for any NaN input |
| busy | output | 1 | Arithmetic operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Estimate or special value, held until the next completion |
| flag_invalid | output | 1 | Invalid-operation flag of the last result |
| flag_divzero | output | 1 | Divide-by-zero flag of the last result |
| flag_denorm_in | output | 1 | Flushed-subnormal-input flag of the last result |

## Verification
The bench builds the unit with its default parameters: the 0x7FC00000 default NaN and the single-precision field widths. These defaults reach the full exponent range. That range covers the odd and even scaling layouts and the deepest subnormal, which needs 22 normalization shifts and gives the largest result exponent. They also reach both ends of the search: a scaled input of 128 runs about 510 increments, and one near 511 runs the fewest. The bench predicts every result, flag and completion latency from the arithmetic rules above. It also drives a zero operand with a start pulse during a running search to show that the pulse is ignored.

// File: rtl/rsqe_pkg.sv
package rsqe_pkg;
  localparam int OP_W       = 32;
  localparam int EXP_W      = 8;
  localparam int FRAC_W     = 23;
  localparam int SCL_W      = 9;
  localparam int EST_W      = 9;
  localparam int B_W        = 10;
  localparam int BP1_W      = B_W + 1;
  localparam int SQ_W       = 2 * BP1_W;
  localparam int PROD_W     = 32;
  localparam int BOUND_LOG2 = 28;
  localparam int B_START    = 512;
  localparam int EXP_SUM    = 380;
  localparam int SEXP_W     = 11;
  localparam int OUT_FRAC   = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_NORM,
    ST_PREP,
    ST_SEARCH
  } rsqe_state_e;

  typedef struct packed {
    logic inv;
    logic dz;
    logic idn;
  } rsqe_flags_t;
endpackage

// File: rtl/rsqe_classify.sv
module rsqe_classify
  import rsqe_pkg::*;
#(
  parameter logic [OP_W-1:0] DEFAULT_NAN = 32'h7FC00000
) (
  input  logic [OP_W-1:0] op,
  input  logic            umode,
  input  logic            ftz,
  input  logic            dnan,
  output logic            sp_hit,
  output logic [OP_W-1:0] sp_res,
  output rsqe_flags_t     sp_flags,
  output logic            needs_norm
);
  localparam logic [EXP_W-1:0] EXP_ONES = '1;
  localparam logic [OP_W-1:0]  QBIT     = OP_W'(1) << (FRAC_W - 1);

  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [FRAC_W-1:0] fr;
  logic is_nan, is_inf, is_sub, is_zero_eff;

  assign sgn = op[OP_W-1];
  assign ex  = op[OP_W-2 -: EXP_W];
  assign fr  = op[FRAC_W-1:0];

  assign is_nan      = (ex == EXP_ONES) && (fr != '0);
  assign is_inf      = (ex == EXP_ONES) && (fr == '0);
  assign is_sub      = (ex == '0) && (fr != '0);
  assign is_zero_eff = (ex == '0) && ((fr == '0) || ftz);

  always_comb begin
    sp_hit   = 1'b0;
    sp_res   = '0;
    sp_flags = '0;
    if (umode) begin
      if (op[OP_W-1 -: 2] == 2'b00) begin
        sp_hit = 1'b1;
        sp_res = '1;
      end
    end else if (is_nan) begin
      sp_hit       = 1'b1;
      sp_flags.inv = ~fr[FRAC_W-1];
      sp_res       = dnan ? DEFAULT_NAN : (op | QBIT);
    end else if (is_zero_eff) begin
      sp_hit       = 1'b1;
      sp_flags.dz  = 1'b1;
      sp_flags.idn = is_sub;
      sp_res       = {sgn, EXP_ONES, {FRAC_W{1'b0}}};
    end else if (sgn) begin
      sp_hit       = 1'b1;
      sp_flags.inv = 1'b1;
      sp_res       = DEFAULT_NAN;
    end else if (is_inf) begin
      sp_hit = 1'b1;
      sp_res = '0;
    end
  end

  assign needs_norm = ~umode & is_sub & ~ftz;
endmodule

// File: rtl/rsqe_search.sv
module rsqe_search
  import rsqe_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SCL_W-1:0] scaled,
  input  logic             step,
  output logic             less,
  output logic [EST_W-1:0] est
);
  localparam logic [PROD_W-1:0] BOUND = PROD_W'(1) << BOUND_LOG2;

  logic [SCL_W:0]    adj_d, adj_q;
  logic [B_W-1:0]    b_q;
  logic [BP1_W-1:0]  bp1;
  logic [SQ_W-1:0]   sq;
  logic [PROD_W-1:0] prod;

  // Input adjustment: odd-form for the lower half, rounded-even form above.
  always_comb begin
    if (scaled[SCL_W-1] == 1'b0) adj_d = {scaled, 1'b1};
    else                         adj_d = {scaled[SCL_W-1:1], 2'b10};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      adj_q <= '0;
      b_q   <= '0;
    end else if (load) begin
      adj_q <= adj_d;
      b_q   <= B_W'(B_START);
    end else if (step) begin
      b_q <= b_q + 1'b1;
    end
  end

  assign bp1  = {1'b0, b_q} + 1'b1;
  assign sq   = bp1 * bp1;
  assign prod = PROD_W'(adj_q) * PROD_W'(sq);
  assign less = prod < BOUND;
  assign est  = EST_W'(bp1 >> 1);
endmodule

// File: rtl/rsqe_top.sv
module rsqe_top
  import rsqe_pkg::*;
#(
  parameter logic [OP_W-1:0] DEFAULT_NAN = 32'h7FC00000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [OP_W-1:0] operand,
  input  logic            mode_fixed,
  input  logic            ftz_en,
  input  logic            dnan_en,
  output logic            busy,
  output logic            done,
  output logic [OP_W-1:0] result,
  output logic            flag_invalid,
  output logic            flag_divzero,
  output logic            flag_denorm_in
);
  localparam logic signed [SEXP_W-1:0] EXP_SUM_S = SEXP_W'(EXP_SUM);

  rsqe_state_e              state_q;
  logic signed [SEXP_W-1:0] exp_q;
  logic [FRAC_W-1:0]        frac_q;
  logic [SCL_W-1:0]         uscl_q;
  logic                     umode_q;
  logic [OP_W-1:0]          res_q;
  rsqe_flags_t              flags_q;
  logic                     done_q;

  logic            sp_hit;
  logic [OP_W-1:0] sp_res;
  rsqe_flags_t     sp_flags;
  logic            needs_norm;

  logic [SCL_W-1:0] scaled;
  logic             s_load, s_step, s_less;
  logic [EST_W-1:0] est;
  logic [EXP_W-1:0] rexp;

  rsqe_classify #(.DEFAULT_NAN(DEFAULT_NAN)) u_cls (
    .op        (operand),
    .umode     (mode_fixed),
    .ftz       (ftz_en),
    .dnan      (dnan_en),
    .sp_hit    (sp_hit),
    .sp_res    (sp_res),
    .sp_flags  (sp_flags),
    .needs_norm(needs_norm)
  );

  // Scaled input: exponent parity picks 7 or 8 fraction bits.
  always_comb begin
    if (umode_q)       scaled = uscl_q;
    else if (exp_q[0]) scaled = {2'b01, frac_q[FRAC_W-1 -: SCL_W-2]};
    else               scaled = {1'b1, frac_q[FRAC_W-1 -: SCL_W-1]};
  end

  assign s_load = (state_q == ST_PREP);
  assign s_step = (state_q == ST_SEARCH) && s_less;

  rsqe_search u_srch (
    .clk   (clk),
    .rst   (rst),
    .load  (s_load),
    .scaled(scaled),
    .step  (s_step),
    .less  (s_less),
    .est   (est)
  );

  assign rexp = EXP_W'((EXP_SUM_S - exp_q) >>> 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      exp_q   <= '0;
      frac_q  <= '0;
      uscl_q  <= '0;
      umode_q <= 1'b0;
      res_q   <= '0;
      flags_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            umode_q <= mode_fixed;
            uscl_q  <= operand[OP_W-1 -: SCL_W];
            exp_q   <= $signed({{(SEXP_W-EXP_W){1'b0}}, operand[OP_W-2 -: EXP_W]});
            frac_q  <= operand[FRAC_W-1:0];
            if (sp_hit) begin
              res_q   <= sp_res;
              flags_q <= sp_flags;
              done_q  <= 1'b1;
            end else if (needs_norm) begin
              state_q <= ST_NORM;
            end else begin
              state_q <= ST_PREP;
            end
          end
        end
        ST_NORM: begin
          frac_q <= frac_q << 1;
          if (frac_q[FRAC_W-1]) state_q <= ST_PREP;
          else                  exp_q   <= exp_q - 11'sd1;
        end
        ST_PREP: begin
          state_q <= ST_SEARCH;
        end
        ST_SEARCH: begin
          if (!s_less) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            flags_q <= '0;
            if (umode_q) res_q <= {est, {(OP_W-EST_W){1'b0}}};
            else         res_q <= {1'b0, rexp, est[OUT_FRAC-1:0], {(FRAC_W-OUT_FRAC){1'b0}}};
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy           = (state_q != ST_IDLE);
  assign done           = done_q;
  assign result         = res_q;
  assign flag_invalid   = flags_q.inv;
  assign flag_divzero   = flags_q.dz;
  assign flag_denorm_in = flags_q.idn;
endmodule

// File: rtl/rsqe_chk.sv
module rsqe_chk #(
  parameter logic [31:0] DEFAULT_NAN = 32'h7FC00000
) (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic [31:0] operand,
  input logic        mode_fixed,
  input logic        ftz_en,
  input logic        busy,
  input logic        done,
  input logic [31:0] result,
  input logic        flag_invalid,
  input logic        flag_divzero,
  input logic        flag_denorm_in
);
  logic um_q;
  always_ff @(posedge clk) begin
    if (rst) um_q <= 1'b0;
    else if (start && !busy) um_q <= mode_fixed;
  end

  AST_UNS_SATURATE: assert property (@(posedge clk) disable iff (rst)
    start && !busy && mode_fixed && operand[31:30] == 2'b00 |=> done && result == 32'hFFFFFFFF); // R10

  AST_UNS_FIELD: assert property (@(posedge clk) disable iff (rst)
    done && um_q && result != 32'hFFFFFFFF |-> result[31] && result[22:0] == 23'h0); // R10

  AST_ZERO_DIVZ: assert property (@(posedge clk) disable iff (rst)
    start && !busy && !mode_fixed && operand[30:0] == 31'h0
    |=> done && flag_divzero && !flag_invalid && !flag_denorm_in
        && result == {$past(operand[31]), 8'hFF, 23'h0}); // R7

  AST_NEG_INVALID: assert property (@(posedge clk) disable iff (rst)
    start && !busy && !mode_fixed && operand[31] && operand[30:0] != 31'h0
    && !(operand[30:23] == 8'hFF && operand[22:0] != 23'h0)
    && !(ftz_en && operand[30:23] == 8'h00)
    |=> done && flag_invalid && result == DEFAULT_NAN); // R8

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    busy |=> busy || done); // R2

  AST_DONE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy) || $past(start)); // R2

  AST_FLOAT_FIELD: assert property (@(posedge clk) disable iff (rst)
    done && !um_q && !flag_invalid && !flag_divzero && result[30:23] != 8'hFF && result != 32'h0
    |-> result[14:0] == 15'h0 && !result[31]); // R4
endmodule

bind rsqe_top rsqe_chk #(.DEFAULT_NAN(DEFAULT_NAN)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .start         (start),
  .operand       (operand),
  .mode_fixed    (mode_fixed),
  .ftz_en        (ftz_en),
  .busy          (busy),
  .done          (done),
  .result        (result),
  .flag_invalid  (flag_invalid),
  .flag_divzero  (flag_divzero),
  .flag_denorm_in(flag_denorm_in)
);

// File: tb/sim_rsqe_top.sv
`timescale 1ns/1ps
module sim_rsqe_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] operand = '0;
  logic        mode_fixed = 1'b0, ftz_en = 1'b0, dnan_en = 1'b0;
  logic        busy, done, flag_invalid, flag_divzero, flag_denorm_in;
  logic [31:0] result;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  rsqe_top u0 (
    .clk(clk), .rst(rst), .start(start), .operand(operand),
    .mode_fixed(mode_fixed), .ftz_en(ftz_en), .dnan_en(dnan_en),
    .busy(busy), .done(done), .result(result),
    .flag_invalid(flag_invalid), .flag_divzero(flag_divzero),
    .flag_denorm_in(flag_denorm_in)
  );

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // Estimate from the scaled input per the search rule; n = increments.
  function automatic int est_of(input int s, output int n);
    longint a, b;
    a = (s < 256) ? (2 * s + 1) : (((s / 2) * 2 + 1) * 2);
    b = 512;
    n = 0;
    while (a * (b + 1) * (b + 1) < (longint'(1) << 28)) begin
      b++;
      n++;
    end
    return int'((b + 1) / 2);
  endfunction

  function automatic void model(input logic [31:0] op, input logic m, input logic f, input logic d,
                                output logic [31:0] r, output logic [2:0] fl, output int lat);
    int e, fr, sh, s, n, est, re;
    logic sub, nan;
    r = '0; fl = '0; lat = 1;
    e = int'(op[30:23]); fr = int'(op[22:0]);
    sub = (e == 0) && (fr != 0);
    nan = (e == 255) && (fr != 0);
    if (m) begin
      if (op[31:30] == 2'b00) begin r = 32'hFFFFFFFF; return; end
      est = est_of(int'(op[31:23]), n);
      r = {est[8:0], 23'h0};
      lat = n + 3;
      return;
    end
    if (nan) begin
      fl[2] = ~op[22];
      r = d ? 32'h7FC00000 : (op | 32'h00400000);
      return;
    end
    if (e == 0 && (fr == 0 || f)) begin
      fl[1] = 1'b1; fl[0] = sub;
      r = {op[31], 8'hFF, 23'h0};
      return;
    end
    if (op[31]) begin fl[2] = 1'b1; r = 32'h7FC00000; return; end
    if (e == 255) begin r = 32'h0; return; end
    sh = 0;
    if (e == 0) begin
      while (((fr >> 22) & 1) == 0) begin fr = fr << 1; e--; sh++; end
      fr = (fr << 1) & 32'h7FFFFF;
    end
    s = (e & 1) ? (128 + (fr >> 16)) : (256 + (fr >> 15));
    est = est_of(s, n);
    re = (380 - e) / 2;
    r = {1'b0, re[7:0], est[7:0], 15'h0};
    lat = n + 3 + ((op[30:23] == 8'h0) ? (sh + 1) : 0);
  endfunction

  // Issue one operation, wait for done, compare with the model.
  task automatic run_op(input string tag, input logic [31:0] op, input logic m,
                        input logic f, input logic d);
    logic [31:0] er; logic [2:0] ef; int el; int cyc;
    model(op, m, f, d, er, ef, el);
    @(negedge clk);
    operand = op; mode_fixed = m; ftz_en = f; dnan_en = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    check(tag, "result", result, er);
    check(tag, "flags", {flag_invalid, flag_divzero, flag_denorm_in}, ef);
    check(tag, "latency", cyc, el);
    @(negedge clk);
    check(tag, "done_pulse_width", done, 0);
  endtask

  task automatic t_reset();
    check("R1", "busy", busy, 0);
    check("R1", "done", done, 0);
    check("R1", "result", result, 0);
    check("R1", "flags", {flag_invalid, flag_divzero, flag_denorm_in}, 0);
  endtask

  task automatic t_normal();
    run_op("R3", 32'h3F800000, 0, 0, 0);   // 1.0, odd exponent, longest search
    run_op("R4", 32'h40000000, 0, 0, 0);   // 2.0, even exponent
    run_op("R4", 32'h40800000, 0, 0, 0);
    run_op("R3", 32'h7F7FFFFF, 0, 0, 0);   // largest finite, short search
    run_op("R11", 32'h3FC90FDB, 0, 0, 0);
    run_op("R4", 32'h42F6E979, 0, 1, 1);   // ftz/dnan do not touch normal operands
  endtask

  task automatic t_denorm();
    run_op("R5", 32'h00000001, 0, 0, 0);   // deepest subnormal
    run_op("R5", 32'h00400000, 0, 0, 0);
    run_op("R5", 32'h0012ABCD, 0, 0, 0);
  endtask

  task automatic t_ftz();
    run_op("R6", 32'h80000001, 0, 1, 0);
    run_op("R6", 32'h00400000, 0, 1, 0);
  endtask

  task automatic t_zero();
    run_op("R7", 32'h00000000, 0, 0, 0);
    run_op("R7", 32'h80000000, 0, 0, 0);
  endtask

  task automatic t_neg_inf();
    run_op("R8", 32'hBF800000, 0, 0, 0);
    run_op("R8", 32'hFF800000, 0, 0, 0);
    run_op("R8", 32'h80000010, 0, 0, 0);
    run_op("R8", 32'h7F800000, 0, 0, 0);
  endtask

  task automatic t_nan();
    run_op("R9", 32'h7F800001, 0, 0, 0);
    run_op("R9", 32'hFFA00000, 0, 0, 0);
    run_op("R9", 32'h7FC12345, 0, 0, 0);
    run_op("R9", 32'h7F800001, 0, 0, 1);
    run_op("R9", 32'hFFC00001, 0, 0, 1);
  endtask

  task automatic t_unsigned();
    run_op("R10", 32'h00000000, 1, 0, 0);
    run_op("R10", 32'h3FFFFFFF, 1, 0, 0);
    run_op("R10", 32'h40000000, 1, 0, 0);
    run_op("R10", 32'h80000000, 1, 0, 0);
    run_op("R10", 32'hFFFFFFFF, 1, 0, 0);
    run_op("R10", 32'h80000000, 1, 1, 1);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] er; logic [2:0] ef; int el; int cyc;
    model(32'h3F800000, 0, 0, 0, er, ef, el);
    @(negedge clk);
    operand = 32'h3F800000; mode_fixed = 0; ftz_en = 0; dnan_en = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    check("R2", "busy_after_start", busy, 1);
    @(negedge clk);
    cyc++;
    operand = 32'h00000000; start = 1'b1;   // zero would finish at once if accepted
    @(negedge clk);
    cyc++;
    start = 1'b0;
    check("R2", "no_early_done", done, 0);
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    check("R2", "result", result, er);
    check("R2", "flags", {flag_invalid, flag_divzero, flag_denorm_in}, ef);
    check("R2", "latency", cyc, el);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R2", "no_extra_done", done, 0);
    end
  endtask

  initial begin
    #(20 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_normal();
    t_denorm();
    t_ftz();
    t_zero();
    t_neg_inf();
    t_nan();
    t_unsigned();
    t_busy_ignore();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule